// File: doc/BRIEF.md
# Preset Square-Wave Tone Source

This block makes a square-wave test tone by running an asynchronous serial transmitter without a break on one fixed byte, 0x55. A frame is a low start bit, eight data bits sent least-significant bit first, and a high stop bit. With that byte, every bit differs from the bit before it, including the bits on each side of a frame boundary. The serial line therefore toggles once per bit period, and the tone frequency is half the bit rate.

A prescaled baud counter sets the bit period. The divisor is taken from a table of four presets, which a 2-bit select input chooses from. A one-byte holding register sits in front of the shift register. It is refilled with the fixed byte as soon as it empties, so each frame's start bit follows the previous stop bit with no idle time. A change of preset takes effect at the next bit boundary. An enable input starts and stops the tone. A strobe marks the last clock of every bit period so that the timing can be observed from outside.

Top module: `tonegen_top`

## Requirements
- R1: While reset is asserted, and from the cycle after any clock edge that samples `en` low, `txLine` is 1 and `bitTick` is 0.
- R2: At the first clock edge that samples `en` high after it was low, the start bit is loaded. `txLine` is 0 from that edge onwards.
- R3: Every bit lasts exactly 4 × (N + 1) clock cycles. N is the preset picked by `freqSel`: 0 gives 50 (204 cycles), 1 gives 47 (192), 2 gives 45 (184) and 3 gives 42 (172).
- R4: While enabled, the line alternates 0, 1, 0, 1 without end. Each frame is start 0, then data bits 1,0,1,0,1,0,1,0 (0x55 sent least-significant bit first), then stop 1. Each frame follows the previous one directly, so no level lasts longer than one bit period.
- R5: `bitTick` is high for exactly one cycle per bit: the last clock cycle of that bit. The line changes at the clock edge that ends a high `bitTick` cycle.
- R6: A change of `freqSel` in the middle of a bit does not change the length of that bit. The new period applies from the next bit onwards.
- R7: When `en` is dropped in the middle of a frame, the frame is abandoned. A later enable starts again with a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the tone while high |
| freqSel | input | 2 | Selects one of the four preset divisors |
| txLine | output | 1 | Serial line carrying the square wave |
| bitTick | output | 1 | High on the last clock cycle of each bit period |

## Verification
The start bit appears one clock edge after `en` is first sampled high, and the line goes back high one edge after `en` is sampled low. After that, each level holds for exactly 4 × (N + 1) cycles, and `bitTick` is high only in the last of those cycles. The bench drives inputs and samples outputs on falling clock edges. It measures every run of constant line level as a count of falling-edge samples, starting from the first sample that shows the new level. It requires the single tick sample to fall on the final sample of the run. For the preset-change case, the bench counts the samples it has already spent inside the current bit. It then expects the remainder of the old period, followed by a full run of the new period.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;

  localparam int DIV_W       = 16;
  localparam int DATA_W      = 8;
  localparam int PRESCALE    = 4;
  localparam int NUM_PRESETS = 4;
  localparam int SEL_W       = $clog2(NUM_PRESETS);
  localparam int FRAME_BITS  = DATA_W + 2;

  localparam logic [DATA_W-1:0] TONE_BYTE = 8'h55;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearLine;
    logic loadFrame;
    logic shiftBit;
    logic refill;
  } txStrobe_t;

  function automatic logic [DIV_W-1:0] presetDiv(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      2'd0:    d = DIV_W'(50);
      2'd1:    d = DIV_W'(47);
      2'd2:    d = DIV_W'(45);
      default: d = DIV_W'(42);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tonegen_ctrl.sv
module tonegen_ctrl
  import tonegen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [SEL_W-1:0] freqSel,
  input  logic             holdFull,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             bitTick
);

  localparam int CNT_W = DIV_W + $clog2(PRESCALE) + 1;
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] activeDiv;
  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] periodLast;
  logic [IDX_W-1:0] bitIdx;
  logic             frameEnd;

  // Last count of a bit period: PRESCALE*(N+1)-1
  assign periodLast = CNT_W'(PRESCALE) * (CNT_W'(activeDiv) + CNT_W'(1)) - CNT_W'(1);
  assign bitTick    = busy && (cycleCnt == periodLast);
  assign frameEnd   = bitTick && (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    strobe.clearLine = !en;
    strobe.loadFrame = en && holdFull && (!busy || frameEnd);
    strobe.shiftBit  = en && bitTick && !frameEnd;
    strobe.refill    = !holdFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cycleCnt  <= '0;
      bitIdx    <= '0;
      activeDiv <= presetDiv('0);
    end else if (!en) begin
      busy      <= 1'b0;
      cycleCnt  <= '0;
      bitIdx    <= '0;
      activeDiv <= presetDiv(freqSel);
    end else if (!busy) begin
      activeDiv <= presetDiv(freqSel);
      cycleCnt  <= '0;
      bitIdx    <= '0;
      busy      <= holdFull;
    end else if (bitTick) begin
      cycleCnt  <= '0;
      activeDiv <= presetDiv(freqSel);
      if (frameEnd) begin
        bitIdx <= '0;
        busy   <= holdFull;
      end else begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
    end else begin
      cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tonegen_dp.sv
module tonegen_dp
  import tonegen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  output logic      holdFull,
  output logic      txLine
);

  logic [DATA_W-1:0]     holdData;
  logic [FRAME_BITS-1:0] shiftReg;

  // Holding register: refilled with the fixed byte whenever it empties
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= TONE_BYTE;
      holdFull <= 1'b1;
    end else if (strobe.loadFrame) begin
      holdFull <= 1'b0;
    end else if (strobe.refill) begin
      holdData <= TONE_BYTE;
      holdFull <= 1'b1;
    end
  end

  // Shift register, bit 0 drives the line; ones shift in behind
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.clearLine) begin
      shiftReg <= '1;
    end else if (strobe.loadFrame) begin
      shiftReg <= {1'b1, holdData, 1'b0};
    end else if (strobe.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign txLine = shiftReg[0];

endmodule

// File: rtl/tonegen_top.sv
module tonegen_top
  import tonegen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic [1:0] freqSel,
  output logic       txLine,
  output logic       bitTick
);

  txStrobe_t strobe;
  logic      holdFull;
  logic      busy;

  tonegen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (en),
    .freqSel  (freqSel),
    .holdFull (holdFull),
    .strobe   (strobe),
    .busy     (busy),
    .bitTick  (bitTick)
  );

  tonegen_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .holdFull (holdFull),
    .txLine   (txLine)
  );

endmodule

// File: rtl/tonegen_chk.sv
module tonegen_chk (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic busy,
  input logic txLine,
  input logic bitTick
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> txLine);

  // R1
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !bitTick);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(en) |=> !txLine);

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R5
  tick_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && en) |=> (txLine != $past(txLine)));

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && busy && !bitTick) |=> $stable(txLine));

endmodule

bind tonegen_top tonegen_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .en      (en),
  .busy    (busy),
  .txLine  (txLine),
  .bitTick (bitTick)
);

// File: tb/test_tonegen_top.sv
`timescale 1ns/1ps
module test_tonegen_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       en;
  logic [1:0] freqSel;
  logic       txLine;
  logic       bitTick;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // {select, expected bit period in cycles}
  localparam int VEC [4][2] = '{'{0, 204}, '{1, 192}, '{2, 184}, '{3, 172}};
  localparam int RUNS = 25;

  always #2 clk = ~clk;

  tonegen_top i_tonegen_top (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .freqSel (freqSel),
    .txLine  (txLine),
    .bitTick (bitTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts the samples of the current level, including the present one.
  // Returns at the first sample of the next level.
  task automatic runLen(output int n, output int ticks, output bit lastTick);
    logic lvl;
    lvl = txLine;
    n = 1;
    ticks = bitTick ? 1 : 0;
    lastTick = bitTick;
    forever begin
      @(negedge clk);
      if (txLine != lvl || n > 2000) break;
      n++;
      if (bitTick) ticks++;
      lastTick = bitTick;
    end
  endtask

  task automatic checkRun(input int expLen, input string req);
    int n;
    int t;
    bit lt;
    runLen(n, t, lt);
    check(n == expLen, req, n, expLen);
    check(t == 1 && lt, "R5", t, 1);
  endtask

  initial begin
    rstN = 1'b0;
    en = 1'b0;
    freqSel = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txLine == 1'b1, "R1", txLine, 1);
    check(bitTick == 1'b0, "R1", bitTick, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R1", txLine, 1);

    // Table walk over all presets
    foreach (VEC[i]) begin
      en = 1'b0;
      freqSel = 2'(VEC[i][0]);
      @(negedge clk);
      // R7: disabled mid-frame gives an idle line
      check(txLine == 1'b1 && bitTick == 1'b0, "R7", txLine, 1);
      repeat (2) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      // R2: start bit after the enabling edge
      check(txLine == 1'b0, "R2", txLine, 0);
      // R3/R4: every level lasts one period across frame boundaries
      for (int r = 0; r < RUNS; r++) begin
        int expLvl;
        expLvl = r % 2;
        check(txLine == expLvl[0], "R4", txLine, expLvl);
        checkRun(VEC[i][1], "R3");
      end
    end

    // R6: preset change in the middle of a bit
    en = 1'b0;
    freqSel = 2'd0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    checkRun(204, "R6");
    repeat (10) @(negedge clk);
    freqSel = 2'd3;
    checkRun(194, "R6");
    checkRun(172, "R6");
    checkRun(172, "R6");

    // R7: re-enable after abandoning a frame restarts with a start bit
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1, "R7", txLine, 1);
    en = 1'b1;
    @(negedge clk);
    check(txLine == 1'b0, "R7", txLine, 0);
    checkRun(172, "R7");

    // R1: idle again after the final disable
    en = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1 && bitTick == 1'b0, "R1", txLine, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule